// File: doc/BRIEF.md
# Microwire Serial Master

This block drives a half-duplex Microwire-style serial link as its master. Each frame sends an 8-bit control word, most significant bit first, on `mosi_o`. One idle clock for bus turnaround follows. Then it samples a response of 4 to 16 bits from `miso_i`. The block generates the serial clock and an active-low chip select. The control words come from a small transmit queue. The responses go into a small receive queue. Both queues use valid/ready handshakes.

There are two framing styles. In single-frame operation, chip select rises one serial clock period after the last response bit is sampled. The response enters the receive queue at that moment. In continuous operation, chip select stays low and the next control word follows the current response with no gap. Each response is committed on the falling clock edge that follows its last bit. The block enters continuous operation only when continuous mode is selected, the next control word is already queued, and the receive queue can take two more words. Otherwise it ends the frame in the single-frame way.

Each frame latches the clock divider and the response length when it starts. A continued frame latches a new response length but keeps the clock divider of the frame that opened the burst.

Top module: `mw_master`

## Requirements
- R1: During and right after reset: `cs_no`=1, `sck_o`=0, `mosi_o`=0, `rx_valid_o`=0 and `tx_ready_o`=1.
- R2: The control word goes out MSB first on the first 8 rising edges of `sck_o` after chip select falls. `mosi_o` changes only while `sck_o` is low, and it holds bit 7 from the moment chip select falls.
- R3: The `sck_o` period is the effective divider in system clocks. The effective divider is `div_i` with bit 0 cleared, and any value below 2 acts as 2. Consecutive rising edges within one chip-select-low window are always exactly one period apart, including across continued frames. `sck_o` is low whenever `cs_no` is high.
- R4: The first rising edge of `sck_o` comes exactly 2.5 periods after `cs_no` falls, which is at least the two periods of setup required.
- R5: Rising edge 9 of a frame is a turnaround and samples nothing. Rising edges 10 to 9+L sample `miso_i` MSB first, where L is `len_i` clamped to 4..16. The word is delivered right-aligned on `rx_data_o`, with the bits above L equal to zero.
- R6: In single-frame operation, `cs_no` rises exactly one period after the last sampling edge. `rx_valid_o` stays low in the system cycle that follows the rise and goes high one cycle later, if the receive queue was empty.
- R7: In continuous mode, while the next control word is queued and at least two receive entries are free, `cs_no` stays low across frames.
- R8: In continuous mode with no control word waiting, the frame ends as in single-frame operation, with `cs_no` high.
- R9: No frame starts while the receive queue has no room for its response. Responses are never lost and come out in the order the control words went in. Each queue holds 4 words by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cont_i | input | 1 | Select continuous framing |
| div_i | input | 8 | Serial clock divider (even, at least 2) |
| len_i | input | 5 | Response length in bits (4 to 16) |
| tx_valid_i | input | 1 | Control word offered |
| tx_data_i | input | 8 | Control word |
| tx_ready_o | output | 1 | Transmit queue has space |
| rx_valid_o | output | 1 | Response word available |
| rx_data_o | output | 16 | Response word, right-aligned |
| rx_ready_i | input | 1 | Consumer takes the response word |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bench keeps a counter of system cycles. It timestamps every edge of `cs_no` and every rising edge of `sck_o`. From these it checks that the first rising edge comes exactly 5·div/2 cycles after chip select falls, that each later rising edge comes exactly div cycles after the one before, and that chip select rises exactly div cycles after the last sampling edge. A device model latches `mosi_o` on the rising edges and drives the response on the falling edges. For single-frame commits, the bench samples `rx_valid_o` at the first and second falling system-clock edges after chip select rises, to cover the one-cycle registered push into the receive queue. Framing and backpressure are checked by counting chip-select windows once the link has settled.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;
  localparam int MW_CTRL_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_END
  } mw_state_e;
endpackage

// File: rtl/mw_fifo.sv
`timescale 1ns/1ps
module mw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> cnt_q != CW'(DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R9
endmodule

// File: rtl/mw_sck_gen.sv
`timescale 1ns/1ps
module mw_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             phase_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             phase_q;
  logic             tick;

  assign tick    = en_i && (cnt_q == half_i - DIV_W'(1));
  assign rise_o  = tick && !phase_q;
  assign fall_o  = tick && phase_q;
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      phase_q <= !phase_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mw_engine.sv
`timescale 1ns/1ps
module mw_engine
  import mw_pkg::*;
#(
  parameter int RESP_MAX = 16,
  parameter int DIV_W    = 8,
  parameter int LEN_W    = 5,
  parameter int FREE_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cont_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                tx_valid_i,
  input  logic [MW_CTRL_W-1:0] tx_data_i,
  output logic                tx_pop_o,
  input  logic [FREE_W-1:0]   rx_free_i,
  output logic                rx_push_o,
  output logic [RESP_MAX-1:0] rx_word_o,
  input  logic                miso_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic                phase_i,
  output logic                clk_en_o,
  output logic [DIV_W-1:0]    half_o,
  output logic                cs_no,
  output logic                sck_o,
  output logic                mosi_o
);
  localparam int BIT_W = $clog2(MW_CTRL_W + RESP_MAX + 2);
  localparam logic [BIT_W-1:0] FIRST_RX = BIT_W'(MW_CTRL_W + 1);

  mw_state_e             state_q;
  logic                  cs_q, clk_en_q, setup_q, last_q, push_q;
  logic [DIV_W-1:0]      half_q;
  logic [LEN_W-1:0]      len_q;
  logic [MW_CTRL_W-1:0]  sh_tx_q;
  logic [RESP_MAX-1:0]   sh_rx_q, word_q;
  logic [BIT_W-1:0]      bit_q;

  logic [DIV_W-1:0] half_raw, eff_half;
  logic [LEN_W-1:0] eff_len;
  logic [BIT_W-1:0] last_idx;
  logic             start, chain;

  assign half_raw = div_i >> 1;
  assign eff_half = (half_raw == '0) ? DIV_W'(1) : half_raw;
  assign eff_len  = (len_i < LEN_W'(4)) ? LEN_W'(4) :
                    (len_i > LEN_W'(RESP_MAX)) ? LEN_W'(RESP_MAX) : len_i;
  assign last_idx = FIRST_RX + BIT_W'(len_q);

  // a push still in flight occupies one entry
  assign start = (state_q == ST_IDLE) && tx_valid_i && (rx_free_i > FREE_W'(push_q));
  assign chain = (state_q == ST_XFER) && fall_i && last_q && cont_i && tx_valid_i &&
                 (rx_free_i >= FREE_W'(2));
  assign tx_pop_o = start || chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_q     <= 1'b1;
      clk_en_q <= 1'b0;
      setup_q  <= 1'b0;
      last_q   <= 1'b0;
      push_q   <= 1'b0;
      half_q   <= DIV_W'(1);
      len_q    <= LEN_W'(4);
      sh_tx_q  <= '0;
      sh_rx_q  <= '0;
      word_q   <= '0;
      bit_q    <= '0;
    end else begin
      push_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          cs_q     <= 1'b0;
          clk_en_q <= 1'b1;
          half_q   <= eff_half;
          len_q    <= eff_len;
          sh_tx_q  <= tx_data_i;
          sh_rx_q  <= '0;
          bit_q    <= '0;
          setup_q  <= 1'b0;
          last_q   <= 1'b0;
          state_q  <= ST_SETUP;
        end
        ST_SETUP: if (fall_i) begin
          if (setup_q) state_q <= ST_XFER;
          else         setup_q <= 1'b1;
        end
        ST_XFER: begin
          if (rise_i) begin
            bit_q <= bit_q + BIT_W'(1);
            if (bit_q >= FIRST_RX)
              sh_rx_q <= {sh_rx_q[RESP_MAX-2:0], miso_i};
            if (bit_q + BIT_W'(1) == last_idx) last_q <= 1'b1;
          end
          if (fall_i) begin
            if (last_q) begin
              if (chain) begin
                push_q  <= 1'b1;
                word_q  <= sh_rx_q;
                sh_tx_q <= tx_data_i;
                sh_rx_q <= '0;
                bit_q   <= '0;
                last_q  <= 1'b0;
                len_q   <= eff_len;
              end else begin
                state_q <= ST_END;
              end
            end else begin
              sh_tx_q <= {sh_tx_q[MW_CTRL_W-2:0], 1'b0};
            end
          end
        end
        ST_END: if (rise_i) begin
          cs_q     <= 1'b1;
          clk_en_q <= 1'b0;
          push_q   <= 1'b1;
          word_q   <= sh_rx_q;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign clk_en_o  = clk_en_q;
  assign half_o    = half_q;
  assign cs_no     = cs_q;
  assign sck_o     = phase_i && (state_q == ST_XFER);
  assign mosi_o    = sh_tx_q[MW_CTRL_W-1];
  assign rx_push_o = push_q;
  assign rx_word_o = word_q;

  // spacing monitors for the timing assertions
  logic [15:0] gap_q, since_q;
  logic        seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      gap_q <= (state_q == ST_IDLE) ? '0 : ((gap_q == '1) ? gap_q : gap_q + 16'd1);
      if (rise_i && state_q == ST_XFER) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else begin
        since_q <= (since_q == '1) ? since_q : since_q + 16'd1;
        if (state_q == ST_IDLE) seen_q <= 1'b0;
      end
    end
  end

  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R3
  AST_MOSI_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o)); // R2
  AST_SETUP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && state_q == ST_XFER && !seen_q) |-> (32'(gap_q) >= 32'(half_q) * 4)); // R4
  AST_CS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && state_q == ST_END) |-> (32'(since_q) + 1 >= 32'(half_q) * 2)); // R6
  AST_CONT_KEEP_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain |=> !cs_no); // R7
endmodule

// File: rtl/mw_master.sv
`timescale 1ns/1ps
module mw_master
  import mw_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int RESP_MAX = 16,
  parameter int DIV_W    = 8,
  localparam int LEN_W   = $clog2(RESP_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cont_i,
  input  logic [DIV_W-1:0]    div_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                tx_valid_i,
  input  logic [7:0]          tx_data_i,
  output logic                tx_ready_o,
  output logic                rx_valid_o,
  output logic [RESP_MAX-1:0] rx_data_o,
  input  logic                rx_ready_i,
  output logic                sck_o,
  output logic                cs_no,
  output logic                mosi_o,
  input  logic                miso_i
);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  logic [TCW-1:0]       tx_cnt;
  logic [RCW-1:0]       rx_cnt, rx_free;
  logic [7:0]           tx_head;
  logic                 tx_pop, rx_push, clk_en, phase, rise, fall;
  logic [RESP_MAX-1:0]  rx_word;
  logic [DIV_W-1:0]     half;

  assign tx_ready_o = tx_cnt != TCW'(TX_DEPTH);
  assign rx_valid_o = rx_cnt != '0;
  assign rx_free    = RCW'(RX_DEPTH) - rx_cnt;

  mw_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (tx_valid_i && tx_ready_o),
    .data_i (tx_data_i),
    .pop_i  (tx_pop),
    .data_o (tx_head),
    .count_o(tx_cnt)
  );

  mw_fifo #(.W(RESP_MAX), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .data_i (rx_word),
    .pop_i  (rx_valid_o && rx_ready_i),
    .data_o (rx_data_o),
    .count_o(rx_cnt)
  );

  mw_sck_gen #(.DIV_W(DIV_W)) u_sck_gen (
    .clk_i, .rst_ni,
    .en_i   (clk_en),
    .half_i (half),
    .phase_o(phase),
    .rise_o (rise),
    .fall_o (fall)
  );

  mw_engine #(.RESP_MAX(RESP_MAX), .DIV_W(DIV_W), .LEN_W(LEN_W), .FREE_W(RCW)) u_engine (
    .clk_i, .rst_ni,
    .cont_i, .div_i, .len_i,
    .tx_valid_i(tx_cnt != '0),
    .tx_data_i (tx_head),
    .tx_pop_o  (tx_pop),
    .rx_free_i (rx_free),
    .rx_push_o (rx_push),
    .rx_word_o (rx_word),
    .miso_i,
    .rise_i    (rise),
    .fall_i    (fall),
    .phase_i   (phase),
    .clk_en_o  (clk_en),
    .half_o    (half),
    .cs_no, .sck_o, .mosi_o
  );
endmodule

// File: tb/mw_master_bench.sv
`timescale 1ns/1ps
module mw_master_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cont_i = 1'b0;
  logic [7:0]  div_i = 8'd4;
  logic [4:0]  len_i = 5'd8;
  logic        tx_valid_i = 1'b0;
  logic [7:0]  tx_data_i = '0;
  logic        tx_ready_o, rx_valid_o, rx_ready_i = 1'b0;
  logic [15:0] rx_data_o;
  logic        sck_o, cs_no, mosi_o, miso_i = 1'b0;

  always #2.5 clk = ~clk;

  mw_master u_mw_master (
    .clk_i(clk), .rst_ni, .cont_i, .div_i, .len_i,
    .tx_valid_i, .tx_data_i, .tx_ready_o,
    .rx_valid_o, .rx_data_o, .rx_ready_i,
    .sck_o, .cs_no, .mosi_o, .miso_i
  );

  int checks = 0, fails = 0, cyc = 0;
  int cur_div = 4, cur_len = 8, rx_mode = 1;
  int cs_falls = 0, cs_rises = 0;
  int t_cs = 0, t_rise = 0, s_cnt = 0;
  bit in_frame = 0, first_rise = 0;
  logic [7:0]  s_ctrl = '0;
  logic [15:0] s_sh = '0;
  logic [7:0]  exp_ctrl[$];
  logic [15:0] exp_rx[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int eff_div(input int d);
    return (d < 2) ? 2 : (d & ~1);
  endfunction
  function automatic int eff_len(input int l);
    return (l < 4) ? 4 : (l > 16) ? 16 : l;
  endfunction
  function automatic logic [15:0] resp_fn(input logic [7:0] c, input int l);
    logic [31:0] m;
    m = (32'd1 << l) - 32'd1;
    return 16'({c ^ 8'h5A, ~c} & m[15:0]);
  endfunction

  always @(posedge clk) cyc++;

  // device model and edge timing
  always @(negedge cs_no) if (rst_ni) begin
    cs_falls++; s_cnt = 0; in_frame = 1; first_rise = 1; t_cs = cyc;
  end
  always @(posedge cs_no) if (rst_ni && in_frame) begin
    cs_rises++; in_frame = 0;
    chk(cyc - t_rise == cur_div, "R6 cs hold", cyc - t_rise, cur_div);
  end
  always @(posedge sck_o) if (!cs_no) begin
    if (s_cnt == 9 + cur_len) s_cnt = 0;
    s_cnt++;
    if (s_cnt <= 8) s_ctrl = {s_ctrl[6:0], mosi_o};
    if (s_cnt == 8) begin
      if (exp_ctrl.size() == 0) chk(0, "R2 unexpected ctrl", s_ctrl, 0);
      else begin
        logic [7:0] e;
        e = exp_ctrl.pop_front();
        chk(s_ctrl == e, "R2 ctrl word", s_ctrl, e);
      end
    end
    if (s_cnt == 9) begin
      logic [15:0] r;
      r = resp_fn(s_ctrl, cur_len);
      exp_rx.push_back(r);
      s_sh = r << (16 - cur_len);
    end
    if (first_rise) chk(cyc - t_cs == 5 * cur_div / 2, "R4 setup", cyc - t_cs, 5 * cur_div / 2);
    else            chk(cyc - t_rise == cur_div, "R3 period", cyc - t_rise, cur_div);
    first_rise = 0;
    t_rise = cyc;
  end
  always @(negedge sck_o) if (!cs_no && s_cnt >= 9 && s_cnt < 9 + cur_len) begin
    miso_i = s_sh[15];
    s_sh = s_sh << 1;
  end

  // consumer and idle-clock check
  always @(negedge clk) begin
    case (rx_mode)
      0:       rx_ready_i = 1'b0;
      1:       rx_ready_i = 1'b1;
      default: rx_ready_i = 1'($urandom % 2);
    endcase
    if (rst_ni && cs_no && sck_o) chk(0, "R3 sck idle low", 1, 0);
    if (rst_ni && rx_valid_o && rx_ready_i) begin
      if (exp_rx.size() == 0) chk(0, "R9 unexpected rx", rx_data_o, 0);
      else begin
        logic [15:0] e;
        e = exp_rx.pop_front();
        chk(rx_data_o == e, "R5 rx word", rx_data_o, e);
      end
    end
  end

  task automatic send(input logic [7:0] w);
    bit hs;
    tx_data_i = w;
    tx_valid_i = 1'b1;
    forever begin
      hs = tx_ready_o;
      @(negedge clk);
      if (hs) break;
    end
    tx_valid_i = 1'b0;
    exp_ctrl.push_back(w);
  endtask

  task automatic wait_idle();
    do @(negedge clk);
    while (!(exp_ctrl.size() == 0 && exp_rx.size() == 0 && cs_no));
    repeat (4) @(negedge clk);
  endtask

  task automatic set_cfg(input int d, input int l, input bit c);
    div_i = 8'(d); len_i = 5'(l); cont_i = c;
    cur_div = eff_div(d); cur_len = eff_len(l);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int f0, r0;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(cs_no && !sck_o && !mosi_o, "R1 reset pins", {cs_no, sck_o, mosi_o}, 3'b100);
    chk(!rx_valid_o && tx_ready_o, "R1 reset queues", {rx_valid_o, tx_ready_o}, 2'b01);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cs_no && !sck_o && !rx_valid_o, "R1 after reset", {cs_no, sck_o, rx_valid_o}, 3'b100);

    // single frame, commit timing
    set_cfg(4, 8, 0);
    rx_mode = 0;
    send(8'hA5);
    @(posedge cs_no);
    @(negedge clk);
    chk(!rx_valid_o, "R6 commit not early", rx_valid_o, 0);
    @(negedge clk);
    chk(rx_valid_o, "R6 commit at cs rise", rx_valid_o, 1);
    chk(rx_data_o == resp_fn(8'hA5, 8), "R6 committed word", rx_data_o, resp_fn(8'hA5, 8));
    rx_mode = 1;
    wait_idle();

    // divider and length clamping
    set_cfg(7, 4, 0);  send(8'h3C); send(8'hC3); wait_idle();
    set_cfg(0, 16, 0); send(8'h01); send(8'hFE); wait_idle();
    set_cfg(3, 20, 0); send(8'h80); wait_idle();
    set_cfg(6, 2, 0);  send(8'h7F); wait_idle();

    // continuous burst
    set_cfg(4, 8, 1);
    f0 = cs_falls; r0 = cs_rises;
    send(8'h11); send(8'h22); send(8'h33);
    wait_idle();
    chk(cs_falls - f0 == 1, "R7 one cs window", cs_falls - f0, 1);
    chk(cs_rises - r0 == 1, "R7 one cs release", cs_rises - r0, 1);

    // continuous selected, nothing queued
    set_cfg(6, 5, 1);
    f0 = cs_falls; r0 = cs_rises;
    send(8'h44);
    wait_idle();
    chk(cs_rises - r0 == 1 && cs_no, "R8 fallback release", cs_rises - r0, 1);
    send(8'h55);
    wait_idle();
    chk(cs_falls - f0 == 2, "R8 new window", cs_falls - f0, 2);

    // receive backpressure
    set_cfg(4, 8, 0);
    rx_mode = 0;
    f0 = cs_falls;
    for (int i = 0; i < 8; i++) send(8'(8'h90 + i));
    repeat (1500) @(negedge clk);
    chk(cs_falls - f0 == 4, "R9 stall when full", cs_falls - f0, 4);
    chk(cs_no, "R9 cs idle while stalled", cs_no, 1);
    rx_mode = 1;
    wait_idle();
    chk(cs_falls - f0 == 8, "R9 all frames done", cs_falls - f0, 8);

    // random batches
    for (int b = 0; b < 8; b++) begin
      set_cfg(2 * (1 + int'($urandom % 4)), int'($urandom % 21), 1'($urandom % 2));
      rx_mode = 2;
      for (int i = 0; i < 6; i++) send(8'($urandom));
      wait_idle();
      rx_mode = 1;
    end
    summary();
  end
endmodule